// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received frames in a circular region of local packet memory. The memory is cut into pages of 2^OFS_W bytes, 256 by default. The ring covers every page from the configured first page up to, but not including, the configured limit page. Frame bytes arrive one per cycle. The first byte lands at byte offset 4 of the current page, and each later byte goes to the next address. When the write pointer runs off the last page of the ring, it wraps back to the first page.

When a frame ends, the block decides whether to keep it, based on the monitor mode, the short-frame and bad-frame policies, and the host-owned boundary page. For a kept frame it fills the four reserved bytes at the start of the first page with a header: status, next page, and a 16-bit byte count. It then moves the current-page pointer on. A dropped frame leaves that pointer where it was.

Payload that would land in the host's boundary page is never written. Such a frame is dropped and an overrun flag is raised. The flag stays up until the host writes a different boundary page.

Top module: `rxr_ring_mgr`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `cur_page` equals `cfg_first_pg`, `mem_we` is 0, `overrun_flag` is 0 and `rx_status` is 0.
- R2: A frame byte sampled at a clock edge is written in the following cycle (`mem_we`=1, `mem_wdata` = that byte). The first byte of a frame goes to offset 4 of page `cur_page`, and each later byte goes to the next byte address.
- R3: After offset 2^OFS_W-1 of a page, writing continues at offset 0 of the following page. The page after `cfg_limit_pg`-1 is `cfg_first_pg`.
- R4: A payload byte is never written when its page equals `host_bound_pg`, unless monitor mode is on (monitor mode writes nothing anyway). Such a byte makes the frame dropped, sets status bit 4 and sets `overrun_flag` at the same edge. `overrun_flag` clears at the first edge where `host_bound_pg` differs from its value at the previous edge.
- R5: For a kept frame, the four cycles after the last payload write carry header writes to offsets 0, 1, 2, 3 of the frame's first page, in that order. The bytes are: the status byte, the next-packet page, count[7:0] and count[15:8]. The count equals the frame length plus 4. Frame bytes offered during these four cycles are ignored.
- R6: `cur_page` changes only at the edge that performs the fourth header write. It then takes the page after the page that holds the frame's last byte, with R3 wrap applied. A dropped frame leaves `cur_page` unchanged.
- R7: With `cfg_monitor`=1, no payload or header is written, and every frame is dropped with status bit 4 set.
- R8: A frame shorter than MIN_LEN bytes is dropped unless `cfg_keep_short`=1. Status bit 3 flags it either way.
- R9: A frame whose last byte carries `rx_crc_err` or `rx_align_err` is dropped unless `cfg_keep_bad`=1. Status bits 1 and 2 record the two errors.
- R10: Status byte encoding: bit 0 = frame kept, bit 1 = CRC error, bit 2 = alignment error, bit 3 = short frame, bit 4 = missed (monitor or overrun), bits 7:5 = 0. `rx_status` holds the byte of the most recent frame from the cycle after its last byte.
- R11: In the cycle after a frame's last byte, exactly one of `evt_stored` (frame kept) or `evt_dropped` pulses, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_first_pg | input | PG_W | First page of the ring |
| cfg_limit_pg | input | PG_W | Page just past the ring's end |
| cfg_monitor | input | 1 | Check frames but store nothing |
| cfg_keep_short | input | 1 | Keep frames shorter than MIN_LEN |
| cfg_keep_bad | input | 1 | Keep frames with CRC or alignment errors |
| host_bound_pg | input | PG_W | Oldest page the host has not yet released |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_crc_err | input | 1 | CRC error, valid with rx_last |
| rx_align_err | input | 1 | Alignment error, valid with rx_last |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PG_W+OFS_W | Byte address {page, offset} |
| mem_wdata | output | 8 | Write data |
| cur_page | output | PG_W | Page where the next frame starts |
| overrun_flag | output | 1 | Boundary overrun seen, held until boundary moves |
| evt_stored | output | 1 | One-cycle pulse: frame kept |
| evt_dropped | output | 1 | One-cycle pulse: frame dropped |
| rx_status | output | 8 | Status byte of the latest frame |

## Verification
The bench builds the block with 32-byte pages (OFS_W=5) and MIN_LEN=8, and runs a four-page ring from page 2 to page 5. With these values a 40-byte frame crosses a page, and a 30-byte frame starting at page 5 wraps back to page 2. Short-frame handling and boundary hits can also be reached with frames of a few dozen bytes. A behavioural model built from queues and integers predicts every output on every cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [0:0] {
        PH_DATA = 1'b0,
        PH_HDR  = 1'b1
    } rxr_phase_e;

    // status byte bit positions (header byte 0 carries the same layout)
    localparam int unsigned STB_OK   = 0;
    localparam int unsigned STB_CRC  = 1;
    localparam int unsigned STB_ALN  = 2;
    localparam int unsigned STB_RUNT = 3;
    localparam int unsigned STB_MISS = 4;

    // bytes reserved in front of every stored frame
    localparam int unsigned HDR_BYTES = 4;

endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
    parameter int unsigned PG_W = 8
) (
    input  logic [PG_W-1:0] pg_i,
    input  logic [PG_W-1:0] first_i,
    input  logic [PG_W-1:0] limit_i,
    output logic [PG_W-1:0] next_o
);
    logic [PG_W-1:0] inc;

    always_comb begin
        inc    = pg_i + 1'b1;
        next_o = (inc == limit_i) ? first_i : inc;
    end
endmodule

// File: rtl/rxr_verdict.sv
module rxr_verdict
    import rxr_pkg::*;
#(
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned MIN_LEN = 64
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic             crc_i,
    input  logic             align_i,
    input  logic             missed_i,
    input  logic             keep_short_i,
    input  logic             keep_bad_i,
    output logic             accept_o,
    output logic [7:0]       status_o
);
    logic runt;
    logic bad;

    always_comb begin
        runt     = len_i < LEN_W'(MIN_LEN);
        bad      = crc_i | align_i;
        accept_o = !missed_i && (!bad || keep_bad_i) && (!runt || keep_short_i);
        status_o           = '0;
        status_o[STB_OK]   = accept_o;
        status_o[STB_CRC]  = crc_i;
        status_o[STB_ALN]  = align_i;
        status_o[STB_RUNT] = runt;
        status_o[STB_MISS] = missed_i;
    end
endmodule

// File: rtl/rxr_hdr_sel.sv
module rxr_hdr_sel #(
    parameter int unsigned LEN_W = 16
) (
    input  logic [1:0]       idx_i,
    input  logic [7:0]       status_i,
    input  logic [7:0]       next_i,
    input  logic [LEN_W-1:0] count_i,
    output logic [7:0]       byte_o
);
    always_comb begin
        unique case (idx_i)
            2'd0:    byte_o = status_i;
            2'd1:    byte_o = next_i;
            2'd2:    byte_o = count_i[7:0];
            default: byte_o = count_i[15:8];
        endcase
    end
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
    import rxr_pkg::*;
#(
    parameter int unsigned PG_W    = 8,
    parameter int unsigned OFS_W   = 8,
    parameter int unsigned MIN_LEN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PG_W-1:0]       cfg_first_pg,
    input  logic [PG_W-1:0]       cfg_limit_pg,
    input  logic                  cfg_monitor,
    input  logic                  cfg_keep_short,
    input  logic                  cfg_keep_bad,
    input  logic [PG_W-1:0]       host_bound_pg,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_last,
    input  logic                  rx_crc_err,
    input  logic                  rx_align_err,
    output logic                  mem_we,
    output logic [PG_W+OFS_W-1:0] mem_addr,
    output logic [7:0]            mem_wdata,
    output logic [PG_W-1:0]       cur_page,
    output logic                  overrun_flag,
    output logic                  evt_stored,
    output logic                  evt_dropped,
    output logic [7:0]            rx_status
);
    localparam int unsigned AW    = PG_W + OFS_W;
    localparam int unsigned LEN_W = 16;

    typedef struct packed {
        rxr_phase_e        ph;
        logic              inf;       // inside a frame
        logic [PG_W-1:0]   wr_pg;
        logic [OFS_W-1:0]  wr_ofs;
        logic [LEN_W-1:0]  len;
        logic              ovf;       // frame hit the boundary page
        logic [1:0]        hidx;
        logic [7:0]        h_status;
        logic [7:0]        h_next;
        logic [LEN_W-1:0]  h_count;
        logic [PG_W-1:0]   cur;
        logic              ovr;
        logic [PG_W-1:0]   bound_seen;
        logic              we;
        logic [AW-1:0]     waddr;
        logic [7:0]        wdata;
        logic              w_hdr;
        logic              stored;
        logic              dropped;
        logic [7:0]        status;
    } ring_state_t;

    ring_state_t s_q, s_d;

    logic [PG_W-1:0]  byte_pg_d;
    logic [OFS_W-1:0] byte_ofs_d;
    logic [PG_W-1:0]  pg_after_d;
    logic [LEN_W-1:0] len_now_d;
    logic             hit_d;
    logic             ovf_now_d;
    logic             accept_d;
    logic [7:0]       verdict_d;
    logic [7:0]       hdr_byte_d;

    always_comb begin
        byte_pg_d  = s_q.inf ? s_q.wr_pg  : s_q.cur;
        byte_ofs_d = s_q.inf ? s_q.wr_ofs : OFS_W'(HDR_BYTES);
        len_now_d  = (s_q.inf ? s_q.len : '0) + LEN_W'(1);
        hit_d      = (s_q.ph == PH_DATA) && rx_valid && !cfg_monitor
                     && (byte_pg_d == host_bound_pg);
        ovf_now_d  = (s_q.inf && s_q.ovf) || hit_d;
    end

    rxr_page_step #(.PG_W(PG_W)) u_step (
        .pg_i    (byte_pg_d),
        .first_i (cfg_first_pg),
        .limit_i (cfg_limit_pg),
        .next_o  (pg_after_d)
    );

    rxr_verdict #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_verdict (
        .len_i        (len_now_d),
        .crc_i        (rx_crc_err),
        .align_i      (rx_align_err),
        .missed_i     (cfg_monitor || ovf_now_d),
        .keep_short_i (cfg_keep_short),
        .keep_bad_i   (cfg_keep_bad),
        .accept_o     (accept_d),
        .status_o     (verdict_d)
    );

    rxr_hdr_sel #(.LEN_W(LEN_W)) u_hdr (
        .idx_i    (s_q.hidx),
        .status_i (s_q.h_status),
        .next_i   (s_q.h_next),
        .count_i  (s_q.h_count),
        .byte_o   (hdr_byte_d)
    );

    always_comb begin
        s_d         = s_q;
        s_d.we      = 1'b0;
        s_d.w_hdr   = 1'b0;
        s_d.stored  = 1'b0;
        s_d.dropped = 1'b0;

        if (hit_d) begin
            s_d.ovr = 1'b1;
        end else if (host_bound_pg != s_q.bound_seen) begin
            s_d.ovr = 1'b0;
        end
        s_d.bound_seen = host_bound_pg;

        unique case (s_q.ph)
            PH_DATA: begin
                if (rx_valid) begin
                    s_d.inf = 1'b1;
                    s_d.ovf = ovf_now_d;
                    s_d.len = len_now_d;
                    if (!cfg_monitor && !ovf_now_d) begin
                        s_d.we    = 1'b1;
                        s_d.waddr = {byte_pg_d, byte_ofs_d};
                        s_d.wdata = rx_data;
                    end
                    s_d.wr_ofs = byte_ofs_d + 1'b1;
                    s_d.wr_pg  = (&byte_ofs_d) ? pg_after_d : byte_pg_d;
                    if (rx_last) begin
                        s_d.inf     = 1'b0;
                        s_d.status  = verdict_d;
                        s_d.stored  = accept_d;
                        s_d.dropped = !accept_d;
                        if (accept_d) begin
                            s_d.ph       = PH_HDR;
                            s_d.hidx     = 2'd0;
                            s_d.h_status = verdict_d;
                            s_d.h_next   = 8'(pg_after_d);
                            s_d.h_count  = len_now_d + LEN_W'(HDR_BYTES);
                        end
                    end
                end
            end
            default: begin
                s_d.we    = 1'b1;
                s_d.w_hdr = 1'b1;
                s_d.waddr = {s_q.cur, OFS_W'(s_q.hidx)};
                s_d.wdata = hdr_byte_d;
                s_d.hidx  = s_q.hidx + 2'd1;
                if (s_q.hidx == 2'd3) begin
                    s_d.ph  = PH_DATA;
                    s_d.cur = PG_W'(s_q.h_next);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.cur        <= cfg_first_pg;
            s_q.bound_seen <= host_bound_pg;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we       = s_q.we;
    assign mem_addr     = s_q.waddr;
    assign mem_wdata    = s_q.wdata;
    assign cur_page     = s_q.cur;
    assign overrun_flag = s_q.ovr;
    assign evt_stored   = s_q.stored;
    assign evt_dropped  = s_q.dropped;
    assign rx_status    = s_q.status;

    // R6
    page_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_page) |-> $past(s_q.ph == PH_HDR && s_q.hidx == 2'd3));

    // R4
    overrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_flag) |-> $past(rx_valid));

    // R4
    no_bound_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !s_q.w_hdr) |-> (mem_addr[AW-1:OFS_W] != $past(host_bound_pg)));

    // R5
    hdr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && s_q.w_hdr) |-> (mem_addr[OFS_W-1:0] < OFS_W'(HDR_BYTES)));

    // R7
    monitor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !s_q.w_hdr) |-> !$past(cfg_monitor));

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_stored && evt_dropped));
endmodule

// File: tb/tb_rxr_ring_mgr.sv
`timescale 1ns/1ps
module tb_rxr_ring_mgr;
    localparam int PG_W    = 8;
    localparam int OFS_W   = 5;
    localparam int MIN_LEN = 8;
    localparam int PS      = 1 << OFS_W;
    localparam int FIRST   = 2;
    localparam int LIMIT   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PG_W-1:0] cfg_first_pg = PG_W'(FIRST);
    logic [PG_W-1:0] cfg_limit_pg = PG_W'(LIMIT);
    logic cfg_monitor = 1'b0, cfg_keep_short = 1'b0, cfg_keep_bad = 1'b0;
    logic [PG_W-1:0] host_bound_pg = PG_W'(1);
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0, rx_align_err = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic mem_we, overrun_flag, evt_stored, evt_dropped;
    logic [PG_W+OFS_W-1:0] mem_addr;
    logic [7:0] mem_wdata, rx_status;
    logic [PG_W-1:0] cur_page;

    always #2 clk = ~clk;

    rxr_ring_mgr #(.PG_W(PG_W), .OFS_W(OFS_W), .MIN_LEN(MIN_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_first_pg(cfg_first_pg), .cfg_limit_pg(cfg_limit_pg),
        .cfg_monitor(cfg_monitor), .cfg_keep_short(cfg_keep_short), .cfg_keep_bad(cfg_keep_bad),
        .host_bound_pg(host_bound_pg), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cur_page(cur_page), .overrun_flag(overrun_flag),
        .evt_stored(evt_stored), .evt_dropped(evt_dropped), .rx_status(rx_status)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int a; int d; } wr_t;
    wr_t hq[$];
    int  m_curr, m_next, m_pg, m_ofs, m_len, m_bound_prev, m_last_pg;
    bit  m_inf, m_ovf, m_ovr, m_hit;
    bit  e_we, e_st, e_dr;
    int  e_addr, e_data, e_status;
    bit  m_missed, m_runt, m_bad, m_acc;
    wr_t w;

    function automatic int wrap(input int p);
        return (p + 1 == LIMIT) ? FIRST : p + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_curr = int'(cfg_first_pg); m_inf = 0; m_ovf = 0; m_ovr = 0;
            e_we = 0; e_st = 0; e_dr = 0; e_status = 0; e_addr = 0; e_data = 0;
            m_bound_prev = int'(host_bound_pg); hq.delete();
        end else begin
            m_hit = 0; e_we = 0; e_st = 0; e_dr = 0;
            if (hq.size() > 0) begin
                w = hq.pop_front();
                e_we = 1; e_addr = w.a; e_data = w.d;
                if (hq.size() == 0) m_curr = m_next;
            end else if (rx_valid) begin
                if (!m_inf) begin
                    m_pg = m_curr; m_ofs = 4; m_len = 0; m_ovf = 0; m_inf = 1;
                end
                if (!cfg_monitor && m_pg == int'(host_bound_pg)) begin
                    m_hit = 1; m_ovf = 1;
                end
                if (!cfg_monitor && !m_ovf) begin
                    e_we = 1; e_addr = m_pg * PS + m_ofs; e_data = int'(rx_data);
                end
                m_len++; m_last_pg = m_pg; m_ofs++;
                if (m_ofs == PS) begin m_ofs = 0; m_pg = wrap(m_pg); end
                if (rx_last) begin
                    m_missed = cfg_monitor || m_ovf;
                    m_runt   = m_len < MIN_LEN;
                    m_bad    = rx_crc_err || rx_align_err;
                    m_acc    = !m_missed && (!m_bad || cfg_keep_bad) && (!m_runt || cfg_keep_short);
                    e_status = int'(m_acc) | (int'(rx_crc_err) << 1) | (int'(rx_align_err) << 2)
                               | (int'(m_runt) << 3) | (int'(m_missed) << 4);
                    e_st = m_acc; e_dr = !m_acc; m_inf = 0;
                    if (m_acc) begin
                        m_next = wrap(m_last_pg);
                        hq.push_back('{m_curr * PS + 0, e_status});
                        hq.push_back('{m_curr * PS + 1, m_next});
                        hq.push_back('{m_curr * PS + 2, (m_len + 4) & 255});
                        hq.push_back('{m_curr * PS + 3, (m_len + 4) >> 8});
                    end
                end
            end
            if (m_hit) m_ovr = 1;
            else if (int'(host_bound_pg) != m_bound_prev) m_ovr = 0;
            m_bound_prev = int'(host_bound_pg);
        end
    end

    // per-cycle comparison, away from the active edge
    bit cmp_on = 1'b0;
    int wr_seen = 0;
    always @(negedge clk) begin
        if (mem_we) wr_seen++;
        if (rst_n && cmp_on) begin
            check(mem_we == e_we, "R2 mem_we", int'(mem_we), int'(e_we));
            if (e_we && mem_we) begin
                check(int'(mem_addr) == e_addr, "R3 mem_addr", int'(mem_addr), e_addr);
                check(int'(mem_wdata) == e_data, "R5 mem_wdata", int'(mem_wdata), e_data);
            end
            check(int'(cur_page) == m_curr, "R6 cur_page", int'(cur_page), m_curr);
            check(overrun_flag == m_ovr, "R4 overrun_flag", int'(overrun_flag), int'(m_ovr));
            check(evt_stored == e_st, "R11 evt_stored", int'(evt_stored), int'(e_st));
            check(evt_dropped == e_dr, "R8 evt_dropped", int'(evt_dropped), int'(e_dr));
            check(int'(rx_status) == e_status, "R10 rx_status", int'(rx_status), e_status);
        end
    end

    task automatic frame(input int n, input bit crc, input bit aln, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
            rx_last  = (i == n - 1);
            rx_crc_err   = (i == n - 1) && crc;
            rx_align_err = (i == n - 1) && aln;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_align_err = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cur_page == PG_W'(FIRST) && !mem_we && !overrun_flag && rx_status == 8'd0,
              "R1 reset state", int'(cur_page), FIRST);
        rst_n = 1'b1;
        @(negedge clk);
        check(cur_page == PG_W'(FIRST) && !mem_we && !overrun_flag,
              "R1 after release", int'(cur_page), FIRST);
        cmp_on = 1'b1;

        frame(10, 0, 0, 8'h10);                 // R2 basic frame, page 2 -> 3
        frame(40, 0, 0, 8'h40);                 // R3 page crossing, 3 -> 5
        frame(30, 0, 0, 8'h80);                 // R3 ring wrap, 5 -> 2 -> next 3
        check(cur_page == PG_W'(3), "R3 wrap next page", int'(cur_page), 3);

        frame(5, 0, 0, 8'h20);                  // R8 short frame dropped
        check(cur_page == PG_W'(3), "R8 short dropped page kept", int'(cur_page), 3);
        cfg_keep_short = 1'b1;
        frame(5, 0, 0, 8'h30);                  // R8 short frame kept
        check(rx_status[3] && rx_status[0], "R8 short kept status", int'(rx_status), 9);
        cfg_keep_short = 1'b0;

        frame(12, 1, 0, 8'h50);                 // R9 CRC error dropped
        check(rx_status == 8'h02, "R9 crc dropped status", int'(rx_status), 2);
        cfg_keep_bad = 1'b1;
        frame(12, 1, 0, 8'h60);                 // R9 CRC error kept
        check(rx_status == 8'h03, "R9 crc kept status", int'(rx_status), 3);
        frame(12, 0, 1, 8'h70);                 // R9 alignment error kept
        check(rx_status == 8'h05, "R9 align kept status", int'(rx_status), 5);
        cfg_keep_bad = 1'b0;

        cfg_monitor = 1'b1;
        wr_seen = 0;
        frame(12, 0, 0, 8'h90);                 // R7 monitor mode
        check(wr_seen == 0, "R7 no writes in monitor", wr_seen, 0);
        check(rx_status == 8'h10, "R7 monitor status", int'(rx_status), 16);
        cfg_monitor = 1'b0;

        host_bound_pg = PG_W'(int'(cur_page) + 1);
        repeat (2) @(negedge clk);
        frame(40, 0, 0, 8'hA0);                 // R4 run into boundary page
        check(overrun_flag == 1'b1, "R4 overrun raised", int'(overrun_flag), 1);
        check(rx_status == 8'h10, "R4 missed status", int'(rx_status), 16);
        host_bound_pg = PG_W'(int'(host_bound_pg) + 1);
        repeat (2) @(negedge clk);
        check(overrun_flag == 1'b0, "R4 overrun cleared", int'(overrun_flag), 0);

        host_bound_pg = cur_page;               // R4 boundary at start page
        repeat (2) @(negedge clk);
        frame(10, 0, 0, 8'hB0);
        check(evt_stored == 1'b0 && overrun_flag, "R4 first byte blocked", int'(overrun_flag), 1);
        host_bound_pg = PG_W'(1);
        repeat (2) @(negedge clk);
        frame(20, 0, 0, 8'hC0);                 // R5 R6 normal frame after recovery

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule